// File: doc/BRIEF.md
# Serial ADC Capture Controller

This block is the host-side master for a 16-bit successive-approximation converter with a three-wire serial link. It runs from a fast system clock and divides that clock to make the converter's data clock. It pulls the active-low select line down once for every sample-rate tick it accepts. The converter uses the opening clocks of each frame to sample its input and then drives a low null bit. After that it shifts the result out MSB first, changing the data line on each falling edge of the data clock. The controller samples the data line on the rising edge of the data clock.

The controller ignores the sampling clocks and uses the null bit to confirm that it is aligned to the frame. It collects as many result bits as the programmed bit count asks for and then ends the frame. Ending early stops the conversion and saves power, because the converter powers down fully whenever the select line is high. When the cross-check is on and the full 16 bits are requested, the controller keeps clocking through the LSB-first repeat of the result and compares the two copies. Each result is held in an output register behind a valid/ready handshake. A tick that arrives while a frame is still running is reported as an overrun.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the select line is high, the data clock is low, `out_valid` is 0 and `overrun` is 0.
- R2: A tick that arrives while the controller is idle pulls the select line low at the next clock edge, with the data clock low. While the select line is low, each high phase and each low phase of the data clock lasts `cfg_div` system cycles. A `cfg_div` of 0 is treated as 1.
- R3: A frame contains exactly 6+N rising data-clock edges. When the cross-check applies, it contains 37 instead. The select line rises on the falling edge that follows the last rising edge, so the data clock is low when the select line goes high.
- R4: The bit count N is `cfg_nbits`, and a value of 0 or above 16 means 16. The bits sampled on rising edges 7 through 6+N form the result MSB first, placed from bit 15 downward. Bits that were not received read as 0.
- R5: `out_frame_err` is 1 when the bit sampled on rising edge 6 (the null bit) is high, and 0 when it is low.
- R6: The cross-check applies only when `cfg_check` is 1 and N is 16. When it applies, the bits sampled on rising edges 23 through 37 are taken as result bits 1 through 15, LSB first. `out_mismatch` is 1 exactly when any of them differs from the MSB-first word. When the cross-check does not apply, `out_mismatch` is 0.
- R7: After the select line rises, it stays high for at least 2·`cfg_div` system cycles before the next frame begins.
- R8: A tick that arrives while a frame or its closing gap is in progress starts no frame and does not disturb the running one. `overrun` is high for one cycle, in the cycle after that tick.
- R9: `out_valid` rises after each frame. While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady. `out_valid` clears in the cycle after a handshake. A frame that finishes while the word has not been taken overwrites that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate pulse that requests a frame |
| cfg_div | input | DIV_W | Half period of the data clock, in system cycles |
| cfg_nbits | input | $clog2(WORD_W+1) | Number of result bits to collect (0 or above 16 means 16) |
| cfg_check | input | 1 | Enable the cross-check against the LSB-first repeat |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Converter data clock |
| adc_sdo | input | 1 | Converter serial data |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | WORD_W | Result word, left-justified |
| out_mismatch | output | 1 | The two copies of the result differed |
| out_frame_err | output | 1 | Null bit was sampled high |
| overrun | output | 1 | A tick arrived while busy |

## Verification
The bench drives a behavioural converter with random words, bit counts from 0 to 20, random dividers, and occasional faults. One fault is a null bit driven high; a controller that is off by one clock would return a word shifted by a bit and would miss that error. Another fault is a single corrupted bit in the LSB-first repeat. It must be flagged only when the bit count is 16 and the check is on; a design that compares short frames, or skips the shared bit 0 incorrectly, would raise false flags. Directed cases cover the edges of the frame and the handshake. Ticks held high must not restart a running frame and must still leave a gap of at least one full data-clock period. A result held against a low ready signal must stay frozen until a later frame overwrites it.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } adcc_state_t;

  // data clocks spent sampling before the null bit is driven
  localparam int unsigned ADCC_SKIP_CLKS = 5;
endpackage

// File: rtl/adcc_sclk_gen.sv
module adcc_sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             term;

  assign term     = en && (cnt == half_div - DIV_W'(1));
  assign rise_evt = term && !sclk;
  assign fall_evt = term && sclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (term) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R2: the data clock parks low once the generator is disabled
  a_r2_sclk_parks_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sclk);
endmodule

// File: rtl/adcc_frame_ctrl.sv
module adcc_frame_ctrl
  import adcc_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned SKIP   = ADCC_SKIP_CLKS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [$clog2(WORD_W+1)-1:0]  nbits,
  input  logic                         check_en,
  input  logic [DIV_W-1:0]             half_div,
  input  logic                         rise_evt,
  input  logic                         fall_evt,
  input  logic                         sdo,
  output logic                         clk_en,
  output logic                         cs_n,
  output logic                         done,
  output logic [WORD_W-1:0]            res_data,
  output logic                         res_mismatch,
  output logic                         res_frame_err,
  output logic                         overrun
);
  localparam int unsigned NB_W = $clog2(WORD_W + 1);
  localparam int unsigned CW   = $clog2(SKIP + 2*WORD_W + 2);
  localparam logic [CW-1:0] NULL_RISE = CW'(SKIP + 1);
  localparam logic [CW-1:0] REP_FIRST = CW'(SKIP + 2 + WORD_W);
  localparam logic [CW-1:0] REP_LAST  = CW'(SKIP + 2*WORD_W);
  localparam logic [NB_W-1:0] FULL_N  = NB_W'(WORD_W);

  adcc_state_t       state;
  logic [CW-1:0]     rcnt, r_next, last_r;
  logic [WORD_W-1:0] sh, rep;
  logic              null_hi, armed, chk_lat;
  logic [NB_W-1:0]   n_lat, n_req, shamt;
  logic              chk_req, in_data, in_rep;
  logic [DIV_W:0]    gcnt, gap_last;

  assign n_req    = (nbits == '0 || nbits > FULL_N) ? FULL_N : nbits;
  assign chk_req  = check_en && (n_req == FULL_N);
  assign r_next   = rcnt + CW'(1);
  assign last_r   = chk_lat ? REP_LAST : (NULL_RISE + CW'(n_lat));
  assign in_data  = (r_next > NULL_RISE) && (r_next <= NULL_RISE + CW'(n_lat));
  assign in_rep   = chk_lat && (r_next >= REP_FIRST) && (r_next <= REP_LAST);
  assign shamt    = FULL_N - n_lat;
  assign gap_last = {half_div, 1'b0} - (DIV_W+1)'(1);
  assign clk_en   = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cs_n          <= 1'b1;
      rcnt          <= '0;
      sh            <= '0;
      rep           <= '0;
      null_hi       <= 1'b0;
      armed         <= 1'b0;
      chk_lat       <= 1'b0;
      n_lat         <= FULL_N;
      gcnt          <= '0;
      done          <= 1'b0;
      res_data      <= '0;
      res_mismatch  <= 1'b0;
      res_frame_err <= 1'b0;
      overrun       <= 1'b0;
    end else begin
      done    <= 1'b0;
      overrun <= tick && (state != ST_IDLE);
      unique case (state)
        ST_IDLE: begin
          if (tick) begin
            state   <= ST_RUN;
            cs_n    <= 1'b0;
            rcnt    <= '0;
            sh      <= '0;
            rep     <= '0;
            null_hi <= 1'b0;
            armed   <= 1'b0;
            n_lat   <= n_req;
            chk_lat <= chk_req;
          end
        end
        ST_RUN: begin
          if (rise_evt) begin
            rcnt <= r_next;
            if (r_next == NULL_RISE) null_hi <= sdo;
            if (in_data) sh  <= {sh[WORD_W-2:0], sdo};
            if (in_rep)  rep <= {sdo, rep[WORD_W-1:1]};
            if (r_next == last_r) armed <= 1'b1;
          end
          if (fall_evt && armed) begin
            state         <= ST_GAP;
            cs_n          <= 1'b1;
            gcnt          <= '0;
            done          <= 1'b1;
            res_data      <= sh << shamt;
            res_mismatch  <= chk_lat && (rep[WORD_W-1:1] != sh[WORD_W-1:1]);
            res_frame_err <= null_hi;
          end
        end
        ST_GAP: begin
          gcnt <= gcnt + (DIV_W+1)'(1);
          if (gcnt == gap_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a frame only opens from idle in answer to a tick
  a_r8_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> ($past(state) == ST_IDLE) && $past(tick));
  // R7: during the closing gap the select stays high and no clock runs
  a_r7_gap_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> cs_n && !clk_en);
  // R8: an overrun pulse always follows a tick
  a_r8_overrun_from_tick: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(tick));
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adcc_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DIV_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [DIV_W-1:0]             cfg_div,
  input  logic [$clog2(WORD_W+1)-1:0]  cfg_nbits,
  input  logic                         cfg_check,
  output logic                         adc_cs_n,
  output logic                         adc_sclk,
  input  logic                         adc_sdo,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [WORD_W-1:0]            out_data,
  output logic                         out_mismatch,
  output logic                         out_frame_err,
  output logic                         overrun
);
  logic [DIV_W-1:0]  div_eff;
  logic              clk_en, rise_evt, fall_evt, done;
  logic [WORD_W-1:0] res_data;
  logic              res_mismatch, res_frame_err;

  assign div_eff = (cfg_div == '0) ? DIV_W'(1) : cfg_div;

  adcc_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .en       (clk_en),
    .half_div (div_eff),
    .sclk     (adc_sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  adcc_frame_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_frame (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .nbits         (cfg_nbits),
    .check_en      (cfg_check),
    .half_div      (div_eff),
    .rise_evt      (rise_evt),
    .fall_evt      (fall_evt),
    .sdo           (adc_sdo),
    .clk_en        (clk_en),
    .cs_n          (adc_cs_n),
    .done          (done),
    .res_data      (res_data),
    .res_mismatch  (res_mismatch),
    .res_frame_err (res_frame_err),
    .overrun       (overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_mismatch  <= 1'b0;
      out_frame_err <= 1'b0;
    end else if (done) begin
      out_valid     <= 1'b1;
      out_data      <= res_data;
      out_mismatch  <= res_mismatch;
      out_frame_err <= res_frame_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: the data clock only rises inside a frame
  a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_sclk) |-> !adc_cs_n);
  // R3: select rises only with the data clock low
  a_r3_cs_rise_clock_low: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> !adc_sclk);
  // R9: a pending word is held while the consumer stalls (no new frame ends)
  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !done) |=>
      out_valid && $stable(out_data) && $stable(out_mismatch) && $stable(out_frame_err));
  // R9: a handshake with no new result clears the valid flag
  a_r9_clear_on_accept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !done) |=> !out_valid);
endmodule

// File: tb/adc_capture_ctrl_test.sv
module adc_capture_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [4:0]  cfg_nbits = 5'd16;
  logic        cfg_check = 1'b0;
  logic        adc_cs_n, adc_sclk;
  logic        adc_sdo = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_mismatch, out_frame_err, overrun;

  int checks = 0;
  int fails  = 0;
  bit wd_fail = 1'b0;
  int cyc = 0;

  logic [15:0] dev_word = 16'h0;
  bit          dev_null_bad = 1'b0;
  bit          dev_corrupt = 1'b0;
  int          fcnt = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_capture_ctrl uut (
    .clk(clk), .rst(rst), .tick(tick), .cfg_div(cfg_div), .cfg_nbits(cfg_nbits),
    .cfg_check(cfg_check), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_mismatch(out_mismatch), .out_frame_err(out_frame_err), .overrun(overrun)
  );

  // behavioural converter: updates its data line on falling data-clock edges
  always @(negedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      fcnt = 0;
      adc_sdo = 1'b1;
    end else begin
      fcnt++;
      if (fcnt == 5) adc_sdo = dev_null_bad;
      else if (fcnt >= 6 && fcnt <= 21) adc_sdo = dev_word[21 - fcnt];
      else if (fcnt >= 22 && fcnt <= 36) begin
        adc_sdo = dev_word[fcnt - 21];
        if (dev_corrupt && fcnt == 30) adc_sdo = ~adc_sdo;
      end else adc_sdo = 1'b1;
    end
  end

  // frame statistics observed at the pins
  logic p_cs = 1'b1, p_sclk = 1'b0;
  bit   infr = 1'b0;
  int   frame_rises = 0, rises_last = 0;
  time  last_t = 0, up_t = 0, frame_min_ph = 0, ph_last = 0, gap_last = 0;
  bit   seen_up = 1'b0;
  always @(adc_sclk or adc_cs_n) begin
    if (adc_sclk !== p_sclk && infr) begin
      if ($time - last_t < frame_min_ph) frame_min_ph = $time - last_t;
      last_t = $time;
      if (adc_sclk) frame_rises++;
    end
    if (adc_cs_n !== p_cs) begin
      if (!adc_cs_n) begin
        infr = 1'b1; frame_rises = 0; frame_min_ph = 1000000; last_t = $time;
        if (seen_up) gap_last = $time - up_t;
      end else begin
        infr = 1'b0; up_t = $time; seen_up = 1'b1;
        rises_last = frame_rises; ph_last = frame_min_ph;
      end
    end
    p_sclk = adc_sclk;
    p_cs   = adc_cs_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      wd_fail = 1'b1;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected fewer)", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int n_eff(input logic [4:0] n);
    return (n == 0 || n > 16) ? 16 : int'(n);
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] w, input logic [4:0] n);
    logic [15:0] mask = 16'hFFFF << (16 - n_eff(n));
    return w & mask;
  endfunction

  function automatic int d_eff(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic start_frame(input logic [15:0] w, input logic [4:0] n, input bit chk,
                             input bit nb, input bit cor, input logic [7:0] dv);
    @(negedge clk);
    dev_word = w; dev_null_bad = nb; dev_corrupt = cor;
    cfg_nbits = n; cfg_check = chk; cfg_div = dv;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_valid();
    int k = 0;
    while (!out_valid && k < 20000) begin @(negedge clk); k++; end
  endtask

  task automatic finish_frame(input logic [15:0] w, input logic [4:0] n, input bit chk,
                              input bit nb, input bit cor, input logic [7:0] dv);
    bit full_chk = chk && n_eff(n) == 16;
    int er = full_chk ? 37 : 6 + n_eff(n);
    wait_valid();
    check(out_valid, "R9", "valid after frame", out_valid, 1);
    check(out_data == exp_word(w, n), "R4", "result word", out_data, exp_word(w, n));
    check(out_frame_err == nb, "R5", "null bit flag", out_frame_err, nb);
    check(out_mismatch == (full_chk && cor), "R6", "repeat mismatch",
          out_mismatch, full_chk && cor);
    check(rises_last == er, "R3", "rising edges per frame", rises_last, er);
    check(ph_last >= time'(d_eff(dv) * CLK_P), "R2", "min clock phase",
          ph_last, d_eff(dv) * CLK_P);
  endtask

  task automatic idle_wait(input logic [7:0] dv);
    repeat (2 * d_eff(dv) + 3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(adc_cs_n && !adc_sclk && !out_valid && !overrun, "R1", "state in reset",
          {adc_cs_n, adc_sclk, out_valid, overrun}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    check(adc_cs_n && !adc_sclk && !out_valid && !overrun, "R1", "state after reset",
          {adc_cs_n, adc_sclk, out_valid, overrun}, 4'b1000);

    // R2: select falls at the edge after the tick with the clock low
    @(negedge clk);
    dev_word = 16'hA5C3; cfg_nbits = 5'd16; cfg_check = 1'b0; cfg_div = 8'd3;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(!adc_cs_n && !adc_sclk, "R2", "select low after tick",
          {adc_cs_n, adc_sclk}, 2'b00);
    finish_frame(16'hA5C3, 5'd16, 1'b0, 1'b0, 1'b0, 8'd3);
    idle_wait(8'd3);

    // directed corners
    start_frame(16'hFFFF, 5'd1, 1'b1, 1'b0, 1'b1, 8'd0);
    finish_frame(16'hFFFF, 5'd1, 1'b1, 1'b0, 1'b1, 8'd0);
    idle_wait(8'd0);
    start_frame(16'h8001, 5'd16, 1'b1, 1'b0, 1'b0, 8'd1);
    finish_frame(16'h8001, 5'd16, 1'b1, 1'b0, 1'b0, 8'd1);
    idle_wait(8'd1);
    start_frame(16'h1234, 5'd0, 1'b1, 1'b1, 1'b1, 8'd2);
    finish_frame(16'h1234, 5'd0, 1'b1, 1'b1, 1'b1, 8'd2);
    idle_wait(8'd2);
    start_frame(16'h0F0F, 5'd15, 1'b1, 1'b0, 1'b1, 8'd1);
    finish_frame(16'h0F0F, 5'd15, 1'b1, 1'b0, 1'b1, 8'd1);
    idle_wait(8'd1);

    // R8: a tick mid-frame pulses overrun and leaves the frame intact
    start_frame(16'h6C39, 5'd16, 1'b0, 1'b0, 1'b0, 8'd2);
    repeat (10) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(overrun, "R8", "overrun pulse", overrun, 1);
    @(negedge clk);
    check(!overrun, "R8", "overrun single cycle", overrun, 0);
    finish_frame(16'h6C39, 5'd16, 1'b0, 1'b0, 1'b0, 8'd2);
    idle_wait(8'd2);

    // R7: ticks held high give back-to-back frames separated by a gap
    @(negedge clk);
    dev_word = 16'h3C5A; cfg_nbits = 5'd8; cfg_check = 1'b0; cfg_div = 8'd3;
    dev_null_bad = 1'b0; dev_corrupt = 1'b0;
    tick = 1'b1;
    wait_valid();
    @(negedge clk);
    wait_valid();
    @(negedge clk);
    while (adc_cs_n) @(negedge clk);
    tick = 1'b0;
    check(gap_last >= time'(6 * CLK_P), "R7", "select high gap", gap_last, 6 * CLK_P);
    finish_frame(16'h3C5A, 5'd8, 1'b0, 1'b0, 1'b0, 8'd3);
    idle_wait(8'd3);

    // R9: stalled consumer holds the word, then a later frame overwrites it
    out_ready = 1'b0;
    start_frame(16'hBEEF, 5'd12, 1'b0, 1'b0, 1'b0, 8'd1);
    finish_frame(16'hBEEF, 5'd12, 1'b0, 1'b0, 1'b0, 8'd1);
    repeat (5) @(negedge clk);
    check(out_valid && out_data == 16'hBEE0, "R9", "held while stalled", out_data, 16'hBEE0);
    idle_wait(8'd1);
    start_frame(16'h1357, 5'd16, 1'b0, 1'b0, 1'b0, 8'd1);
    while (!adc_cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
    check(out_valid && out_data == 16'h1357, "R9", "overwrite pending word",
          out_data, 16'h1357);
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R9", "valid clears after accept", out_valid, 0);
    idle_wait(8'd1);

    // constrained random frames
    for (int i = 0; i < 40; i++) begin
      logic [15:0] w  = 16'($urandom);
      logic [4:0]  n  = 5'($urandom_range(0, 20));
      bit          c  = 1'($urandom);
      bit          nb = ($urandom_range(0, 7) == 0);
      bit          co = ($urandom_range(0, 3) == 0);
      logic [7:0]  dv = 8'($urandom_range(0, 4));
      if (i % 3 == 0) n = 5'd16;
      start_frame(w, n, c, nb, co, dv);
      finish_frame(w, n, c, nb, co, dv);
      idle_wait(dv);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule